// File: doc/BRIEF.md
# Programmable Serial Byte Transmitter

This block sends bytes over a single serial line that rests high between frames. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The bit time is a whole number of cycles of the block clock, and an option byte chooses it. With a 76800 Hz clock the four rates are 2400, 4800, 9600 and 19200 baud.

A host presents a byte on an 8-bit port and fires a strobe. The strobe may be much shorter than one clock period, so a flag set by the strobe edge itself catches it. The flag is then synchronised into the clock domain and cleared once the byte has been taken. A select input, held steady around the strobe, marks the byte as payload (0) or as an option byte (1). A new option byte applies from the next frame. A payload byte that arrives while a frame is on the line waits and goes out after that frame.

Top module: `uart_tx_prog`

## Requirements
- R1: After reset, `txd` is 1 and `busy` is 0, and the option set is 9600 baud (8 cycles per bit), no parity and one stop bit.
- R2: Whenever `busy` is 0, `txd` is 1.
- R3: A frame is a start bit of 0, then payload bits 0 through 7 in that order, then stop bits of 1.
- R4: The option byte bits [1:0] set the bit time: 00 gives 32 cycles, 01 gives 16, 10 gives 8 and 11 gives 4. Every bit of a frame lasts exactly that many cycles.
- R5: Option bit 2 set to 1 inserts a parity bit after payload bit 7. Option bit 3 picks its sense: with 0 it makes the count of ones in payload plus parity even, and with 1 it makes that count odd.
- R6: Option bit 4 gives one stop bit when 0 and two stop bits when 1.
- R7: A strobe shorter than one clock period is still captured. With `wr_is_cfg` at 0 the byte is sent as payload, and with `wr_is_cfg` at 1 bits [4:0] are taken as options.
- R8: A payload byte strobed during a frame is sent right after that frame. An option byte strobed during a frame leaves that frame unchanged and governs the next one.
- R9: `busy` rises with the start bit, stays 1 through the last stop bit, and is 0 one half cycle after the last stop bit ends.
- R10: Writing an option byte starts no frame: `txd` stays 1 and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the bit-time reference |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Short active-high strobe marking a valid byte |
| wr_is_cfg | input | 1 | Byte type: 0 payload, 1 option byte |
| wr_byte | input | 8 | Payload or option byte |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | High while a frame is on the line |

## Verification
The line is sampled at the middle of each bit and compared against a frame built from the payload and options. Payloads of all zeros, all ones and single set bits at either end show up bit-order swaps and parity-sense errors. Single-bit payloads at each rate code measure the start bit length, which separates the four divisors. Random option and payload pairs cover parity and stop-count combinations. A directed overlap, with a payload and an option byte strobed during a running frame, shows whether the options are snapshotted at the frame start and whether the waiting payload is held.

// File: rtl/uart_tx_prog_pkg.sv
package uart_tx_prog_pkg;

  typedef enum logic [1:0] {
    RATE_SLOWEST = 2'b00,
    RATE_SLOW    = 2'b01,
    RATE_MID     = 2'b10,
    RATE_FAST    = 2'b11
  } rate_e;

  // Packed so that option byte bits [4:0] map straight onto it.
  typedef struct packed {
    logic  two_stop;
    logic  par_odd;
    logic  par_en;
    rate_e rate;
  } tx_opts_t;

  localparam tx_opts_t OPTS_RESET = '{two_stop: 1'b0, par_odd: 1'b0,
                                      par_en: 1'b0, rate: RATE_MID};

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } tx_state_e;

endpackage

// File: rtl/strobe_catch.sv
// Catches a strobe narrower than a clock period: the strobe edge sets a flag
// and loads the holding registers; the clock domain clears the flag.
module strobe_catch #(
  parameter int DW = 8
) (
  input  logic          strobe_i,
  input  logic          clr_i,
  input  logic [DW-1:0] byte_i,
  input  logic          sel_i,
  output logic          flag_o,
  output logic [DW-1:0] byte_o,
  output logic          sel_o
);

  always_ff @(posedge strobe_i or posedge clr_i) begin
    if (clr_i) flag_o <= 1'b0;
    else       flag_o <= 1'b1;
  end

  always_ff @(posedge strobe_i) begin
    byte_o <= byte_i;
    sel_o  <= sel_i;
  end

endmodule

// File: rtl/cmd_sync.sv
// Brings the caught flag into the clock domain and issues one write pulse
// per strobe, plus an acknowledge that clears the flag.
module cmd_sync #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flag_i,
  input  logic [DW-1:0] byte_i,
  input  logic          sel_i,
  output logic          ack_o,
  output logic          data_we_o,
  output logic          opts_we_o,
  output logic [DW-1:0] byte_o
);

  logic [STAGES:0] sync_q;
  logic            seen;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-1:0], flag_i};
  end

  assign seen = sync_q[STAGES-1] & ~sync_q[STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o     <= 1'b0;
      data_we_o <= 1'b0;
      opts_we_o <= 1'b0;
      byte_o    <= '0;
    end else begin
      ack_o     <= seen;
      data_we_o <= seen & ~sel_i;
      opts_we_o <= seen & sel_i;
      if (seen) byte_o <= byte_i;
    end
  end

  // R7
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    (data_we_o | opts_we_o) |=> !(data_we_o | opts_we_o));

  // R7
  we_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_we_o, opts_we_o}));

endmodule

// File: rtl/tx_frame.sv
// Option store, one-deep payload holding slot and the frame shifter.
module tx_frame
  import uart_tx_prog_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BASE_DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_we_i,
  input  logic          opts_we_i,
  input  logic [DW-1:0] byte_i,
  output logic          txd_o,
  output logic          busy_o
);

  localparam int MAX_LEN = BASE_DIV * 8;
  localparam int CW      = $clog2(MAX_LEN);
  localparam int IW      = $clog2(DW);

  tx_opts_t      opts_next, opts_act;
  tx_state_e     state;
  logic [DW-1:0] pend_data, shreg;
  logic          pend_v, par_bit;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bit_idx;
  logic [CW:0]   bit_len;
  logic          last_tick;

  always_comb begin
    bit_len   = (CW+1)'(BASE_DIV) << (2'd3 - opts_act.rate);
    last_tick = ({1'b0, cnt} == bit_len - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opts_next <= OPTS_RESET;
      opts_act  <= OPTS_RESET;
      state     <= ST_IDLE;
      pend_data <= '0;
      pend_v    <= 1'b0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      cnt       <= '0;
      bit_idx   <= '0;
      txd_o     <= 1'b1;
      busy_o    <= 1'b0;
    end else begin
      if (opts_we_i) opts_next <= tx_opts_t'(byte_i[4:0]);

      if (state == ST_IDLE) begin
        txd_o  <= 1'b1;
        busy_o <= 1'b0;
        if (pend_v) begin
          state    <= ST_START;
          txd_o    <= 1'b0;
          busy_o   <= 1'b1;
          cnt      <= '0;
          shreg    <= pend_data;
          opts_act <= opts_next;
          par_bit  <= (^pend_data) ^ opts_next.par_odd;
          pend_v   <= 1'b0;
        end
      end else if (!last_tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (state)
          ST_START: begin
            state   <= ST_DATA;
            bit_idx <= '0;
            txd_o   <= shreg[0];
          end
          ST_DATA: begin
            if (bit_idx == IW'(DW-1)) begin
              state <= opts_act.par_en ? ST_PAR : ST_STOP1;
              txd_o <= opts_act.par_en ? par_bit : 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= shreg >> 1;
              txd_o   <= shreg[1];
            end
          end
          ST_PAR: begin
            state <= ST_STOP1;
            txd_o <= 1'b1;
          end
          ST_STOP1: begin
            if (opts_act.two_stop) begin
              state <= ST_STOP2;
            end else begin
              state  <= ST_IDLE;
              busy_o <= 1'b0;
            end
          end
          default: begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
          end
        endcase
      end

      if (data_we_i) begin
        pend_data <= byte_i;
        pend_v    <= 1'b1;
      end
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> txd_o);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !txd_o);

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && cnt != '0) |-> $stable(txd_o));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> ({1'b0, cnt} < bit_len));

  // R5
  par_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAR) |-> opts_act.par_en);

  // R6
  stop_two_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP2) |-> opts_act.two_stop);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> txd_o);

endmodule

// File: rtl/uart_tx_prog.sv
module uart_tx_prog #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_strobe,
  input  logic              wr_is_cfg,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              txd,
  output logic              busy
);

  logic              flag, hold_sel, ack, clr, data_we, opts_we;
  logic [DATA_W-1:0] hold_byte, clk_byte;

  assign clr = rst | ack;

  strobe_catch #(.DW(DATA_W)) u_catch (
    .strobe_i (wr_strobe),
    .clr_i    (clr),
    .byte_i   (wr_byte),
    .sel_i    (wr_is_cfg),
    .flag_o   (flag),
    .byte_o   (hold_byte),
    .sel_o    (hold_sel)
  );

  cmd_sync #(.DW(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .flag_i    (flag),
    .byte_i    (hold_byte),
    .sel_i     (hold_sel),
    .ack_o     (ack),
    .data_we_o (data_we),
    .opts_we_o (opts_we),
    .byte_o    (clk_byte)
  );

  tx_frame #(.DW(DATA_W), .BASE_DIV(BASE_DIV)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .data_we_i (data_we),
    .opts_we_i (opts_we),
    .byte_i    (clk_byte),
    .txd_o     (txd),
    .busy_o    (busy)
  );

endmodule

// File: tb/uart_tx_prog_tb.sv
module uart_tx_prog_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] byt = 8'h00;
  logic       txd, busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  uart_tx_prog u_dut (
    .clk       (clk),
    .rst       (rst),
    .wr_strobe (stb),
    .wr_is_cfg (sel),
    .wr_byte   (byt),
    .txd       (txd),
    .busy      (busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] r);
    return 4 << (3 - int'(r));
  endfunction

  function automatic int nbits(input logic [4:0] o);
    return 10 + int'(o[2]) + int'(o[4]);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input logic [4:0] o, input int i);
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (i == 9 && o[2]) return (^d) ^ o[3];
    return 1'b1;
  endfunction

  // Strobe 3 ns wide, well under the 20 ns clock period (R7).
  task automatic send(input logic [7:0] b, input logic s);
    @(negedge clk);
    #3;
    byt = b;
    sel = s;
    #2 stb = 1'b1;
    #3 stb = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic wait_start(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (txd == 1'b0) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic watch(input logic [7:0] d, input logic [4:0] o, input string req);
    bit seen;
    int len, n;
    len = blen(o[1:0]);
    n   = nbits(o);
    wait_start(seen);
    chk(seen, {req, " start seen"}, int'(seen), 1);
    if (!seen) return;
    repeat (len / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(txd === exp_bit(d, o, i), $sformatf("%s bit %0d", req, i), int'(txd), int'(exp_bit(d, o, i)));
      chk(busy === 1'b1, $sformatf("R9 busy in bit %0d", i), int'(busy), 1);
      if (i < n - 1) repeat (len) @(negedge clk);
    end
    repeat (len / 2) @(negedge clk);
    chk(busy === 1'b0, "R9 busy low after frame", int'(busy), 0);
    chk(txd === 1'b1, "R2 idle high after frame", int'(txd), 1);
  endtask

  task automatic measure_start(input int exp_len);
    bit seen;
    int cnt;
    wait_start(seen);
    cnt = 0;
    while (seen && txd == 1'b0 && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp_len, "R4 start bit length", cnt, exp_len);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);

    // R1 default options: 9600, no parity, one stop
    fork
      watch(8'hA5, 5'b00010, "R1");
      send(8'hA5, 1'b0);
    join

    // R10 option write alone starts nothing
    begin
      bit quiet;
      quiet = 1'b1;
      send(8'h03, 1'b1);
      repeat (60) begin
        @(negedge clk);
        if (txd !== 1'b1 || busy !== 1'b0) quiet = 1'b0;
      end
      chk(quiet, "R10 no frame on option write", int'(quiet), 1);
    end

    // R4 each rate code
    for (int r = 0; r < 4; r++) begin
      send(8'(r), 1'b1);
      fork
        measure_start(blen(2'(r)));
        send(8'h01, 1'b0);
      join
    end

    // R3 bit order with one set bit at either end, R5 parity sense
    send(8'h02, 1'b1);
    fork watch(8'h01, 5'b00010, "R3"); send(8'h01, 1'b0); join
    fork watch(8'h80, 5'b00010, "R3"); send(8'h80, 1'b0); join
    send(8'h0E, 1'b1);
    fork watch(8'h00, 5'b01110, "R5 odd"); send(8'h00, 1'b0); join
    send(8'h06, 1'b1);
    fork watch(8'hFF, 5'b00110, "R5 even"); send(8'hFF, 1'b0); join
    // R6 two stop bits
    send(8'h13, 1'b1);
    fork watch(8'h3C, 5'b10011, "R6"); send(8'h3C, 1'b0); join

    // R8 payload and options written during a running frame
    send(8'h03, 1'b1);
    fork
      begin
        watch(8'h5A, 5'b00011, "R8 first");
        watch(8'hC3, 5'b11100, "R8 second");
      end
      begin
        send(8'h5A, 1'b0);
        repeat (5) @(negedge clk);
        send(8'h1C, 1'b1);
        send(8'hC3, 1'b0);
      end
    join

    // R7 random option and payload pairs
    for (int it = 0; it < 16; it++) begin
      logic [4:0] o;
      logic [7:0] d;
      o = 5'($urandom);
      d = 8'($urandom);
      send({3'b000, o}, 1'b1);
      fork
        watch(d, o, "R7 random");
        send(d, 1'b0);
      join
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule